// File: doc/BRIEF.md
# Three-Level Stepped Carrier Generator

This block builds one period of a low-distortion carrier out of a fast oversampling clock. A clock-enable tick, running at 160 times the wanted signaling frequency, steps a period counter. From the counter position the block drives two digital phase pins. Off chip the two pins are summed through resistors into a three-level staircase: top rail, midpoint, bottom rail. Each half-cycle holds the full level for roughly two thirds of its length and the midpoint for the remaining third. With that duty, the third harmonic and its odd multiples (9, 15, ...) cancel, and the half-wave symmetry removes all even harmonics. An analog filter downstream then has far less work to do.

Frequency shift keying is done upstream by switching the rate of the tick. Because every output edge sits on a tick, the phase jump at a frequency change is at most one tick, which is 2.25 degrees of the 160-tick period. An enable input pauses the waveform where it stands. A kill input parks the pins at the midpoint at once and rewinds the period to its start. A one-clock marker flags the start of every period.

Top module: `stepwave_gen`

## Requirements
- R1: While rst_ni is low and after its release, the period count is 0, the pins show the midpoint (phase_a_o=0, phase_b_o=1), and cyc_start_o is 0.
- R2: The period count advances by one on each clock where tick_i=1, enable_i=1 and kill_i=0. It wraps from PERIOD_TICKS-1 (159) to 0, so one period spans 160 ticks.
- R3: The pin encoding is as follows. Top level is phase_a_o=1 and phase_b_o=1. Bottom level is 0,0. Midpoint is phase_a_o=0 and phase_b_o=1.
- R4: Counts 0..79 form the positive half and counts 80..159 the negative half. In each half, the first DB_LEAD (14) positions are midpoint, the next 53 are full level, and the last 13 are midpoint (DB_TICKS=27 midpoint positions per half).
- R5: Over one whole period there are exactly 53 top positions, 53 bottom positions and 54 midpoint positions.
- R6: cyc_start_o is high for exactly one clock, the clock after the edge on which the count wraps to 0. This happens once per period.
- R7: With enable_i=0, ticks are ignored: the count and the pins hold.
- R8: kill_i=1 forces the midpoint on the pins in the same cycle, without waiting for a clock edge. It takes priority over enable_i and tick_i, and it clears the count to 0. After release, the waveform restarts from count 0.
- R9: Without an accepted tick and with kill_i low, the pins do not change.
- R10: The pins never step directly between top and bottom. Every polarity change passes through the midpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling clock-enable tick |
| enable_i | input | 1 | Run control; low freezes the waveform |
| kill_i | input | 1 | Forces the midpoint and rewinds the period |
| phase_a_o | output | 1 | First phase pin to the resistive sum |
| phase_b_o | output | 1 | Second phase pin to the resistive sum |
| cyc_start_o | output | 1 | One-clock marker at the start of a period |

## Verification
The bench builds the block with its default values: a 160-tick period, 27 midpoint ticks per half and 14 of them leading. With these values, every segment boundary (13/14, 66/67, 79/80, 93/94, 146/147 and the wrap at 159/0) can be reached within a few hundred ticks, and the 53/53/54 level split can be checked exactly over a full period. The small lead/tail asymmetry also shows whether the split positions are placed as parameterised.

// File: rtl/stepwave_pkg.sv
package stepwave_pkg;
  typedef enum logic [1:0] {
    LVL_MID = 2'd0,
    LVL_POS = 2'd1,
    LVL_NEG = 2'd2
  } level_e;
endpackage

// File: rtl/stepwave_cnt.sv
module stepwave_cnt #(
  parameter int PERIOD_TICKS = 160,
  localparam int CW = $clog2(PERIOD_TICKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          enable_i,
  input  logic          kill_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (kill_i) begin
        cnt_q <= '0;
      end else if (tick_i && enable_i) begin
        if (cnt_q == LAST) begin
          cnt_q  <= '0;
          wrap_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/stepwave_dec.sv
module stepwave_dec
  import stepwave_pkg::*;
#(
  parameter int PERIOD_TICKS = 160,
  parameter int DB_TICKS     = 27,
  parameter int DB_LEAD      = 14,
  localparam int CW = $clog2(PERIOD_TICKS)
) (
  input  logic [CW-1:0] cnt_i,
  output level_e        level_o
);
  localparam int HALF     = PERIOD_TICKS / 2;
  localparam int ACT_TICKS = HALF - DB_TICKS;
  localparam logic [CW-1:0] HALF_C    = CW'(HALF);
  localparam logic [CW-1:0] ACT_BEG_C = CW'(DB_LEAD);
  localparam logic [CW-1:0] ACT_END_C = CW'(DB_LEAD + ACT_TICKS);

  logic          neg_half;
  logic [CW-1:0] pos_in_half;
  logic          active;

  always_comb begin
    neg_half    = (cnt_i >= HALF_C);
    pos_in_half = neg_half ? (cnt_i - HALF_C) : cnt_i;
    active      = (pos_in_half >= ACT_BEG_C) && (pos_in_half < ACT_END_C);
    if (!active)      level_o = LVL_MID;
    else if (neg_half) level_o = LVL_NEG;
    else               level_o = LVL_POS;
  end
endmodule

// File: rtl/stepwave_drv.sv
module stepwave_drv
  import stepwave_pkg::*;
(
  input  level_e level_i,
  input  logic   kill_i,
  output logic   phase_a_o,
  output logic   phase_b_o
);
  // kill bypasses the counter path so the park is immediate
  always_comb begin
    if (kill_i) begin
      phase_a_o = 1'b0;
      phase_b_o = 1'b1;
    end else begin
      unique case (level_i)
        LVL_POS: begin phase_a_o = 1'b1; phase_b_o = 1'b1; end
        LVL_NEG: begin phase_a_o = 1'b0; phase_b_o = 1'b0; end
        default: begin phase_a_o = 1'b0; phase_b_o = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/stepwave_gen.sv
module stepwave_gen
  import stepwave_pkg::*;
#(
  parameter int PERIOD_TICKS = 160,
  parameter int DB_TICKS     = 27,
  parameter int DB_LEAD      = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic enable_i,
  input  logic kill_i,
  output logic phase_a_o,
  output logic phase_b_o,
  output logic cyc_start_o
);
  localparam int CW = $clog2(PERIOD_TICKS);

  logic [CW-1:0] cnt;
  level_e        level;

  stepwave_cnt #(.PERIOD_TICKS(PERIOD_TICKS)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .enable_i (enable_i),
    .kill_i   (kill_i),
    .cnt_o    (cnt),
    .wrap_o   (cyc_start_o)
  );

  stepwave_dec #(
    .PERIOD_TICKS(PERIOD_TICKS),
    .DB_TICKS    (DB_TICKS),
    .DB_LEAD     (DB_LEAD)
  ) u_dec (
    .cnt_i   (cnt),
    .level_o (level)
  );

  stepwave_drv u_drv (
    .level_i   (level),
    .kill_i    (kill_i),
    .phase_a_o (phase_a_o),
    .phase_b_o (phase_b_o)
  );
endmodule

// File: rtl/stepwave_chk.sv
module stepwave_chk #(
  parameter int PERIOD_TICKS = 160,
  localparam int CW = $clog2(PERIOD_TICKS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          enable_i,
  input logic          kill_i,
  input logic          phase_a_o,
  input logic          phase_b_o,
  input logic          cyc_start_o,
  input logic [CW-1:0] cnt
);
  logic run;
  assign run = tick_i && enable_i && !kill_i;

  a_r2_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < CW'(PERIOD_TICKS));

  a_r6_start_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |-> (cnt == '0));

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |=> !cyc_start_o);

  a_r7_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !kill_i) |=> (cnt == $past(cnt)));

  a_r8_kill_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |-> (!phase_a_o && phase_b_o));

  a_r8_kill_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> (cnt == '0));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (kill_i || $stable({phase_a_o, phase_b_o})));

  a_r10_no_pos_to_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_a_o && phase_b_o) |=> !(!phase_a_o && !phase_b_o));

  a_r10_no_neg_to_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phase_a_o && !phase_b_o) |=> !(phase_a_o && phase_b_o));
endmodule

bind stepwave_gen stepwave_chk #(.PERIOD_TICKS(PERIOD_TICKS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .enable_i    (enable_i),
  .kill_i      (kill_i),
  .phase_a_o   (phase_a_o),
  .phase_b_o   (phase_b_o),
  .cyc_start_o (cyc_start_o),
  .cnt         (cnt)
);

// File: tb/sim_stepwave_gen.sv
`timescale 1ns/1ps
module sim_stepwave_gen;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic enable_i = 1'b0;
  logic kill_i = 1'b0;
  logic phase_a_o, phase_b_o, cyc_start_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stepwave_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .enable_i(enable_i),
    .kill_i(kill_i), .phase_a_o(phase_a_o), .phase_b_o(phase_b_o),
    .cyc_start_o(cyc_start_o)
  );

  // resistive sum model: +1 top, -1 bottom, 0 midpoint (R3)
  function automatic int lvl();
    if (phase_a_o && phase_b_o) return 1;
    if (!phase_a_o && !phase_b_o) return -1;
    return 0;
  endfunction

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // one tick pulse; sample at the following falling edge
  task automatic do_tick();
    tick_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // {advance ticks, expected level, expected strobe}; starts at count 0
  localparam int NV = 11;
  localparam int VEC [NV][3] = '{
    '{13,  0, 0},  // 13  lead midpoint
    '{1,   1, 0},  // 14  top begins
    '{52,  1, 0},  // 66  last top
    '{1,   0, 0},  // 67  tail midpoint
    '{13,  0, 0},  // 80  negative half lead
    '{13,  0, 0},  // 93  last lead
    '{1,  -1, 0},  // 94  bottom begins
    '{52, -1, 0},  // 146 last bottom
    '{1,   0, 0},  // 147 tail midpoint
    '{12,  0, 0},  // 159
    '{1,   0, 1}   // wrap to 0
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int npos, nneg, nmid, nstr, prev, jumps;
    // R1 reset
    idle(3);
    chk("R1 level in reset", lvl(), 0);
    chk("R1 pin a in reset", int'(phase_a_o), 0);
    chk("R1 strobe in reset", int'(cyc_start_o), 0);
    rst_ni = 1'b1;
    idle(2);
    chk("R1 level after release", lvl(), 0);
    enable_i = 1'b1;

    // R2 R4 R6: table walk
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < VEC[v][0]; k++) do_tick();
      chk($sformatf("R4 vector %0d level", v), lvl(), VEC[v][1]);
      chk($sformatf("R6 vector %0d strobe", v), int'(cyc_start_o), VEC[v][2]);
    end

    // R5 R6 R10: one full period
    npos = 0; nneg = 0; nmid = 0; nstr = 0; jumps = 0; prev = lvl();
    for (int k = 0; k < 160; k++) begin
      do_tick();
      if (lvl() == 1) npos++; else if (lvl() == -1) nneg++; else nmid++;
      if (cyc_start_o) nstr++;
      if (lvl() * prev == -1) jumps++;
      prev = lvl();
    end
    chk("R5 top count", npos, 53);
    chk("R5 bottom count", nneg, 53);
    chk("R5 midpoint count", nmid, 54);
    chk("R6 strobes per period", nstr, 1);
    chk("R10 direct polarity jumps", jumps, 0);
    idle(1);
    chk("R6 strobe one clock wide", int'(cyc_start_o), 0);

    // R7 enable low ignores ticks
    for (int k = 0; k < 20; k++) do_tick();
    chk("R2 count 20 top", lvl(), 1);
    enable_i = 1'b0;
    for (int k = 0; k < 100; k++) do_tick();
    chk("R7 frozen level", lvl(), 1);
    chk("R7 no strobe while frozen", int'(cyc_start_o), 0);
    enable_i = 1'b1;
    for (int k = 0; k < 46; k++) do_tick();
    chk("R7 resumes at 66 top", lvl(), 1);
    do_tick();
    chk("R7 resumes at 67 midpoint", lvl(), 0);

    // R9 no tick, outputs hold
    idle(10);
    chk("R9 hold without tick", lvl(), 0);

    // R8 kill
    for (int k = 0; k < 33; k++) do_tick();
    chk("R4 count 100 bottom", lvl(), -1);
    kill_i = 1'b1;
    #0.5;
    chk("R8 immediate midpoint", lvl(), 0);
    @(negedge clk);
    for (int k = 0; k < 5; k++) do_tick();
    chk("R8 ticks under kill midpoint", lvl(), 0);
    kill_i = 1'b0;
    for (int k = 0; k < 13; k++) do_tick();
    chk("R8 restart count 13 midpoint", lvl(), 0);
    do_tick();
    chk("R8 restart count 14 top", lvl(), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule